// File: doc/BRIEF.md
# Shared Load/Store Port Arbiter with Secure Preemption

This block sits between a CPU load/store unit and its device ports and merges in a second requester, a security core. Both requesters present a valid flag, a device index, a write enable, an address and write data. Each device port uses a request/acknowledge handshake of variable latency. If a device drops its request before acknowledging, that device cancels the access and leaves no side effects. The arbiter lets the two requesters use different devices in the same cycle. On a shared device the security core always wins.

When the CPU is stalled on a slow device and a secure request for that same device arrives before the acknowledge, the arbiter withdraws the CPU access. It drops the device request for one cycle so the device cancels cleanly, and then serves the secure access. After that it reissues the CPU access from a held copy of its fields. The CPU sees only a longer stall. An access the device has already acknowledged is complete and is never reissued. A saturating counter records how many CPU accesses were displaced, for debug.

Top module: `lsu_shared_arbiter`

## Requirements
- R1: A CPU access and a secure access to different devices proceed in parallel. Each one completes with its unshared latency: for a device latency L, the CPU completes L+1 cycles after its valid cycle and the secure core completes L cycles after its valid cycle.
- R2: When both requesters target the same idle device in the same cycle, the secure access completes first, after L cycles. The CPU access is then driven in the cycle after the secure completion, so it completes after 2L+1 cycles.
- R3: If a secure request targets the device that the CPU access was driving in the previous cycle without an acknowledge, that device's request is held low for exactly one cycle. The displaced CPU access never completes at that point.
- R4: After a displacement, the CPU access is reissued with the same write enable, address and write data once the secure access completes. The CPU completes s+2+2L cycles after its valid cycle, where s is the cycle in which the secure request arrived and L is the device latency.
- R5: The CPU stall output is high from the cycle in which a CPU access is presented until, but not including, its completion cycle.
- R6: The CPU completion pulse and the CPU read data come only from a device acknowledge of the CPU's own access. The CPU read data is zero in every other cycle. The secure read data at secure completion is the data returned by the targeted device.
- R7: A CPU access that has been acknowledged is committed exactly once. A secure request to the same device that arrives after that acknowledge is served without a gap and without a displacement count.
- R8: The displacement counter increments by one for each displaced CPU access and stays unchanged otherwise. It saturates at its maximum value.
- R9: A secure access drives its device request in its own valid cycle when no displacement is needed. A CPU access is captured in its valid cycle and drives the device request from the next cycle.
- R10: During reset and immediately after it, no device request is asserted, the stall output is low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU access request, held until completion |
| cpuDev | input | DEVW | CPU target device index |
| cpuWe | input | 1 | CPU write enable |
| cpuAddr | input | AW | CPU address |
| cpuWdata | input | DW | CPU write data |
| cpuStall | output | 1 | CPU must hold its pipeline |
| cpuDone | output | 1 | CPU access completed this cycle |
| cpuRdata | output | DW | CPU read data, valid with cpuDone |
| secValid | input | 1 | Secure access request, held until completion |
| secDev | input | DEVW | Secure target device index |
| secWe | input | 1 | Secure write enable |
| secAddr | input | AW | Secure address |
| secWdata | input | DW | Secure write data |
| secDone | output | 1 | Secure access completed this cycle |
| secRdata | output | DW | Secure read data, valid with secDone |
| devReq | output | NDEV | Per-device request |
| devWe | output | NDEV | Per-device write enable |
| devAddr | output | NDEV*AW | Per-device address, device d at bits d*AW |
| devWdata | output | NDEV*DW | Per-device write data, device d at bits d*DW |
| devAck | input | NDEV | Per-device acknowledge, valid only while its request is high |
| devRdata | input | NDEV*DW | Per-device read data, device d at bits d*DW |
| preemptCount | output | CNTW | Saturating count of displaced CPU accesses |

## Verification
Lone CPU accesses and lone secure accesses with random devices, latencies and addresses set the baseline latency and data for each requester. Concurrent accesses to distinct devices separate true parallel service from serialisation. Simultaneous arrival on one device shows the priority order, and this case must not count a displacement. A secure arrival on a device that the CPU is already driving, placed at random points up to and including the acknowledge cycle, checks the cancel gap, the replay and the counter. A secure arrival one cycle after a CPU acknowledge checks that a finished CPU store is not reissued.

// File: rtl/lsu_arb_pkg.sv
package lsu_arb_pkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic capture;  // latch the CPU request into the replay register
    logic cpuDone;  // CPU access acknowledged by its device
    logic secDone;  // secure access acknowledged by its device
  } arbStrobe_t;
endpackage

// File: rtl/lsu_arb_ctrl.sv
module lsu_arb_ctrl
  import lsu_arb_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int DEVW = 2,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuValid,
  input  logic            secValid,
  input  logic [DEVW-1:0] secDev,
  input  logic [DEVW-1:0] replayDev,
  input  logic [NDEV-1:0] devAck,
  output logic [NDEV-1:0] grantCpu,
  output logic [NDEV-1:0] grantSec,
  output arbStrobe_t      strobe,
  output logic            cpuStall,
  output logic [CNTW-1:0] preemptCount
);
  logic            cpuBusy;
  logic [NDEV-1:0] lastCpu;   // device was driven by an unacknowledged CPU access last cycle
  logic [NDEV-1:0] secWant;
  logic [NDEV-1:0] cpuWant;
  logic [NDEV-1:0] displace;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign secWant[d]  = secValid && (secDev == DEVW'(d));
    assign cpuWant[d]  = cpuBusy && (replayDev == DEVW'(d));
    // A secure access replacing a live CPU access waits one cycle with the request low.
    assign displace[d] = secWant[d] & lastCpu[d];
    assign grantSec[d] = secWant[d] & ~lastCpu[d];
    assign grantCpu[d] = cpuWant[d] & ~secWant[d];
  end

  always_comb begin
    strobe.capture = cpuValid & ~cpuBusy;
    strobe.cpuDone = |(grantCpu & devAck);
    strobe.secDone = |(grantSec & devAck);
  end

  assign cpuStall = strobe.capture | (cpuBusy & ~strobe.cpuDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuBusy      <= 1'b0;
      lastCpu      <= '0;
      preemptCount <= '0;
    end else begin
      if (strobe.capture)      cpuBusy <= 1'b1;
      else if (strobe.cpuDone) cpuBusy <= 1'b0;
      lastCpu <= grantCpu & ~devAck;
      if ((|displace) && (preemptCount != {CNTW{1'b1}}))
        preemptCount <= preemptCount + 1'b1;
    end
  end
endmodule

// File: rtl/lsu_arb_dpath.sv
module lsu_arb_dpath
  import lsu_arb_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int DEVW = 2,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [DEVW-1:0]   cpuDev,
  input  logic              cpuWe,
  input  logic [AW-1:0]     cpuAddr,
  input  logic [DW-1:0]     cpuWdata,
  input  logic [DEVW-1:0]   secDev,
  input  logic              secWe,
  input  logic [AW-1:0]     secAddr,
  input  logic [DW-1:0]     secWdata,
  input  logic [NDEV-1:0]   grantCpu,
  input  logic [NDEV-1:0]   grantSec,
  input  logic [NDEV*DW-1:0] devRdata,
  output logic [DEVW-1:0]   replayDev,
  output logic [NDEV-1:0]   devReq,
  output logic [NDEV-1:0]   devWe,
  output logic [NDEV*AW-1:0] devAddr,
  output logic [NDEV*DW-1:0] devWdata,
  output logic [DW-1:0]     cpuRdata,
  output logic [DW-1:0]     secRdata
);
  logic          rWe;
  logic [AW-1:0] rAddr;
  logic [DW-1:0] rWdata;
  logic [DW-1:0] rdArr [NDEV];

  // Replay register: the CPU access exactly as presented, kept until it completes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      replayDev <= '0;
      rWe       <= 1'b0;
      rAddr     <= '0;
      rWdata    <= '0;
    end else if (strobe.capture) begin
      replayDev <= cpuDev;
      rWe       <= cpuWe;
      rAddr     <= cpuAddr;
      rWdata    <= cpuWdata;
    end else if (strobe.cpuDone) begin
      rWe       <= 1'b0;
      rAddr     <= '0;
      rWdata    <= '0;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_port
    assign devReq[d] = grantCpu[d] | grantSec[d];
    assign devWe[d]  = grantSec[d] ? secWe : (grantCpu[d] & rWe);
    assign devAddr[d*AW +: AW]  = grantSec[d] ? secAddr  : (grantCpu[d] ? rAddr  : '0);
    assign devWdata[d*DW +: DW] = grantSec[d] ? secWdata : (grantCpu[d] ? rWdata : '0);
    assign rdArr[d] = devRdata[d*DW +: DW];
  end

  // Responses are steered by requester; each side sees only its own completion.
  assign cpuRdata = strobe.cpuDone ? rdArr[replayDev] : '0;
  assign secRdata = strobe.secDone ? rdArr[secDev]    : '0;
endmodule

// File: rtl/lsu_shared_arbiter.sv
module lsu_shared_arbiter
  import lsu_arb_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int CNTW = 16,
  localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuValid,
  input  logic [DEVW-1:0]    cpuDev,
  input  logic               cpuWe,
  input  logic [AW-1:0]      cpuAddr,
  input  logic [DW-1:0]      cpuWdata,
  output logic               cpuStall,
  output logic               cpuDone,
  output logic [DW-1:0]      cpuRdata,
  input  logic               secValid,
  input  logic [DEVW-1:0]    secDev,
  input  logic               secWe,
  input  logic [AW-1:0]      secAddr,
  input  logic [DW-1:0]      secWdata,
  output logic               secDone,
  output logic [DW-1:0]      secRdata,
  output logic [NDEV-1:0]    devReq,
  output logic [NDEV-1:0]    devWe,
  output logic [NDEV*AW-1:0] devAddr,
  output logic [NDEV*DW-1:0] devWdata,
  input  logic [NDEV-1:0]    devAck,
  input  logic [NDEV*DW-1:0] devRdata,
  output logic [CNTW-1:0]    preemptCount
);
  arbStrobe_t      strobe;
  logic [NDEV-1:0] grantCpu;
  logic [NDEV-1:0] grantSec;
  logic [DEVW-1:0] replayDev;

  lsu_arb_ctrl #(.NDEV(NDEV), .DEVW(DEVW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .secValid(secValid),
    .secDev(secDev), .replayDev(replayDev), .devAck(devAck),
    .grantCpu(grantCpu), .grantSec(grantSec), .strobe(strobe),
    .cpuStall(cpuStall), .preemptCount(preemptCount)
  );

  lsu_arb_dpath #(.NDEV(NDEV), .DEVW(DEVW), .AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuDev(cpuDev), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .secDev(secDev), .secWe(secWe), .secAddr(secAddr), .secWdata(secWdata),
    .grantCpu(grantCpu), .grantSec(grantSec), .devRdata(devRdata),
    .replayDev(replayDev), .devReq(devReq), .devWe(devWe),
    .devAddr(devAddr), .devWdata(devWdata),
    .cpuRdata(cpuRdata), .secRdata(secRdata)
  );

  assign cpuDone = strobe.cpuDone;
  assign secDone = strobe.secDone;
endmodule

// File: rtl/lsu_shared_arbiter_chk.sv
module lsu_shared_arbiter_chk #(
  parameter int NDEV = 4,
  parameter int CNTW = 16,
  localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            secValid,
  input logic [DEVW-1:0] secDev,
  input logic            secDone,
  input logic            cpuStall,
  input logic            cpuDone,
  input logic [NDEV-1:0] devReq,
  input logic [NDEV-1:0] devAck,
  input logic [CNTW-1:0] preemptCount
);
  // R1: at most one device per requester is driven
  p_dual_issue_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(devReq) <= 2);

  // R2: a secure request waits at most one cancel cycle for its device
  p_sec_served_r2: assert property (@(posedge clk) disable iff (!rstN)
    (secValid && $past(secValid) && ($past(secDev) == secDev) && !$past(secDone))
      |-> devReq[secDev]);

  // R5: a stalled CPU stays stalled until it completes
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && !cpuDone) |=> (cpuStall || cpuDone));

  // R6: CPU completion needs a device acknowledge
  p_cpu_done_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (devAck != '0));

  // R8: the displacement counter moves by at most one per cycle
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (preemptCount == $past(preemptCount)) || (preemptCount == $past(preemptCount) + 1'b1));
endmodule

bind lsu_shared_arbiter lsu_shared_arbiter_chk #(.NDEV(NDEV), .CNTW(CNTW)) u_chk (
  .clk(clk), .rstN(rstN), .secValid(secValid), .secDev(secDev), .secDone(secDone),
  .cpuStall(cpuStall), .cpuDone(cpuDone), .devReq(devReq), .devAck(devAck),
  .preemptCount(preemptCount)
);

// File: tb/lsu_shared_arbiter_bench.sv
module lsu_shared_arbiter_bench;
  localparam int NDEV = 4, AW = 16, DW = 32, CNTW = 16, DEVW = 2;

  logic clk = 1'b0;
  logic rstN;
  logic cpuValid, cpuWe, secValid, secWe;
  logic [DEVW-1:0] cpuDev, secDev;
  logic [AW-1:0] cpuAddr, secAddr;
  logic [DW-1:0] cpuWdata, secWdata, cpuRdata, secRdata;
  logic cpuStall, cpuDone, secDone;
  logic [NDEV-1:0] devReq, devWe, devAck;
  logic [NDEV*AW-1:0] devAddr;
  logic [NDEV*DW-1:0] devWdata, devRdata;
  logic [CNTW-1:0] preemptCount;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsu_shared_arbiter #(.NDEV(NDEV), .AW(AW), .DW(DW), .CNTW(CNTW)) u_lsu_shared_arbiter (.*);

  // Device models: ack after lat[d] cycles of continuous request; dropping request cancels.
  int lat [NDEV];
  int cnt [NDEV];
  int commits [NDEV];
  logic lastWe [NDEV];
  logic [AW-1:0] lastAddr [NDEV];
  logic [DW-1:0] lastWdata [NDEV];

  function automatic logic [DW-1:0] devData(int d, logic [AW-1:0] a);
    return {a, ~a} ^ (32'h5A3C_0F96 + 32'(d));
  endfunction

  for (genvar g = 0; g < NDEV; g++) begin : g_model
    assign devAck[g] = devReq[g] && (cnt[g] == lat[g]);
    assign devRdata[g*DW +: DW] = devData(g, devAddr[g*AW +: AW]);
    always @(posedge clk) begin
      if (!rstN) begin
        cnt[g] <= 0; commits[g] <= 0;
      end else begin
        cnt[g] <= (!devReq[g] || devAck[g]) ? 0 : cnt[g] + 1;
        if (devReq[g] && devAck[g]) begin
          commits[g]   <= commits[g] + 1;
          lastWe[g]    <= devWe[g];
          lastAddr[g]  <= devAddr[g*AW +: AW];
          lastWdata[g] <= devWdata[g*DW +: DW];
        end
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpuAccess(input int dev, input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, output int latOut,
                           output logic [DW-1:0] rd, output logic quietOk);
    int c0;
    cpuValid = 1; cpuDev = DEVW'(dev); cpuWe = we; cpuAddr = a; cpuWdata = wd;
    c0 = cyc; latOut = -1; rd = '0; quietOk = 1;
    for (int k = 0; k < 400; k++) begin
      #1;
      if (cpuDone) begin latOut = cyc - c0; rd = cpuRdata; break; end
      if (cpuRdata != '0 || !cpuStall) quietOk = 0;
      @(negedge clk);
    end
    @(negedge clk);
    cpuValid = 0;
  endtask

  task automatic secAccess(input int dev, input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int delay, output int latOut,
                           output logic [DW-1:0] rd, output logic firstReq);
    int c0;
    repeat (delay) @(negedge clk);
    secValid = 1; secDev = DEVW'(dev); secWe = we; secAddr = a; secWdata = wd;
    c0 = cyc; latOut = -1; rd = '0; firstReq = 0;
    for (int k = 0; k < 400; k++) begin
      #1;
      if (k == 0) firstReq = devReq[dev];
      if (secDone) begin latOut = cyc - c0; rd = secRdata; break; end
      @(negedge clk);
    end
    @(negedge clk);
    secValid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cl, sl, c0m, s, L, d1, d2;
    logic [DW-1:0] crd, srd;
    logic q, fr, cw;
    logic [AW-1:0] ca, sa;
    logic [DW-1:0] cwd;
    logic [CNTW-1:0] pc0;
    void'($urandom(32'd20240611));
    rstN = 0; cpuValid = 0; secValid = 0; cpuWe = 0; secWe = 0;
    cpuDev = '0; secDev = '0; cpuAddr = '0; secAddr = '0; cpuWdata = '0; secWdata = '0;
    for (int d = 0; d < NDEV; d++) lat[d] = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset devReq", devReq, 0);
    check("R10 reset stall", cpuStall, 0);
    check("R10 reset count", preemptCount, 0);
    @(negedge clk); rstN = 1; @(negedge clk);
    #1;
    check("R10 after reset devReq", devReq, 0);
    @(negedge clk);

    // CPU alone
    for (int i = 0; i < 30; i++) begin
      d1 = $urandom % NDEV; lat[d1] = $urandom % 4;
      cw = 1'($urandom); ca = AW'($urandom); cwd = $urandom;
      c0m = commits[d1];
      cpuAccess(d1, cw, ca, cwd, cl, crd, q);
      check("R9 cpu latency", cl, lat[d1] + 1);
      check("R6 cpu rdata", crd, devData(d1, ca));
      check("R5 R6 cpu stall and quiet", q, 1);
      #1;
      check("R7 cpu single commit", commits[d1], c0m + 1);
      check("R4 cpu fields", {lastWe[d1], lastAddr[d1], lastWdata[d1]}, {cw, ca, cwd});
      @(negedge clk);
    end

    // Secure alone
    for (int i = 0; i < 30; i++) begin
      d2 = $urandom % NDEV; lat[d2] = $urandom % 4; sa = AW'($urandom);
      secAccess(d2, 1'($urandom), sa, $urandom, 0, sl, srd, fr);
      check("R9 sec latency", sl, lat[d2]);
      check("R9 sec same-cycle request", fr, 1);
      check("R6 sec rdata", srd, devData(d2, sa));
      @(negedge clk);
    end

    // Different devices in parallel
    for (int i = 0; i < 20; i++) begin
      d1 = $urandom % NDEV; d2 = (d1 + 1 + $urandom % (NDEV - 1)) % NDEV;
      lat[d1] = $urandom % 4; lat[d2] = $urandom % 4;
      ca = AW'($urandom); sa = AW'($urandom); pc0 = preemptCount;
      fork
        cpuAccess(d1, 1'b0, ca, '0, cl, crd, q);
        secAccess(d2, 1'b0, sa, '0, 0, sl, srd, fr);
      join
      check("R1 parallel cpu latency", cl, lat[d1] + 1);
      check("R1 parallel sec latency", sl, lat[d2]);
      check("R6 parallel cpu rdata", crd, devData(d1, ca));
      check("R6 parallel sec rdata", srd, devData(d2, sa));
      check("R8 parallel no count", preemptCount, pc0);
      @(negedge clk);
    end

    // Same device, same cycle
    for (int i = 0; i < 10; i++) begin
      d1 = $urandom % NDEV; L = $urandom % 4; lat[d1] = L;
      ca = AW'($urandom); sa = AW'($urandom); pc0 = preemptCount; c0m = commits[d1];
      fork
        cpuAccess(d1, 1'b0, ca, '0, cl, crd, q);
        secAccess(d1, 1'b1, sa, $urandom, 0, sl, srd, fr);
      join
      check("R2 sec first latency", sl, L);
      check("R2 cpu after sec latency", cl, 2 * L + 1);
      check("R6 cpu rdata not secure", crd, devData(d1, ca));
      check("R2 no displacement", preemptCount, pc0);
      check("R2 two commits", commits[d1], c0m + 2);
      @(negedge clk);
    end

    // Displacement of a live CPU access, then replay
    for (int i = 0; i < 15; i++) begin
      d1 = $urandom % NDEV; L = 2 + $urandom % 4; lat[d1] = L;
      s = 2 + $urandom % L;
      cw = 1'($urandom); ca = AW'($urandom); cwd = $urandom; sa = AW'($urandom);
      pc0 = preemptCount; c0m = commits[d1];
      fork
        cpuAccess(d1, cw, ca, cwd, cl, crd, q);
        secAccess(d1, 1'b1, sa, $urandom, s, sl, srd, fr);
      join
      check("R3 cancel gap", fr, 0);
      check("R3 sec latency after gap", sl, L + 1);
      check("R4 replay latency", cl, s + 2 + 2 * L);
      check("R6 replay rdata", crd, devData(d1, ca));
      check("R5 R6 replay stall and quiet", q, 1);
      check("R8 count step", preemptCount, pc0 + 1'b1);
      #1;
      check("R3 two commits only", commits[d1], c0m + 2);
      check("R4 replay fields", {lastWe[d1], lastAddr[d1], lastWdata[d1]}, {cw, ca, cwd});
      @(negedge clk);
    end

    // Secure arrives right after the CPU acknowledge
    for (int i = 0; i < 10; i++) begin
      d1 = $urandom % NDEV; L = $urandom % 4; lat[d1] = L;
      ca = AW'($urandom); cwd = $urandom; pc0 = preemptCount; c0m = commits[d1];
      fork
        cpuAccess(d1, 1'b1, ca, cwd, cl, crd, q);
        secAccess(d1, 1'b0, AW'($urandom), '0, L + 2, sl, srd, fr);
      join
      check("R7 cpu latency", cl, L + 1);
      check("R7 sec no gap", fr, 1);
      check("R7 sec latency", sl, L);
      check("R7 no displacement", preemptCount, pc0);
      #1;
      check("R7 committed once", commits[d1], c0m + 2);
      @(negedge clk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule